// File: doc/BRIEF.md
# Serial Link Bring-Up Handshake Controller

This block brings a point-to-point serial link into service between two identical peers. Each peer owns a transceiver. The controller tells its transceiver when to send the raw synchronization pattern, chooses the word placed on the transmit path, and watches two inputs: the lock indication from its own transceiver and the words received from the far end. The block puts a sync pattern, a flag word naming its current phase, or user data on the transmit path. Each phase names itself with a fixed 16-bit flag code, and the codes rise in phase order. A peer can therefore tell whether the far end has reached a given phase, or a later one, with a single magnitude check on the received word.

Bring-up runs in this order. The controller waits for a steady lock. It then alternates between a sync burst and a flag burst until it has seen enough of the far end's flags. It passes through two acknowledge phases and then declares the link up. From that point, user data goes straight to the transmit path. If lock is lost in any phase, the whole sequence starts again. Every threshold is a parameter. The defaults are 0x200000 locked cycles, bursts of 240 cycles, 0x0FFF matched flag cycles, 240 acknowledge cycles and a second-acknowledge timeout of 4096 cycles.

Top module: `link_handshake`

## Requirements
- R1: While reset is asserted, and right after it is released, sync_req_o is 1, link_up_o is 0 and tx_word_o equals the SYNC_WORD parameter (default 16'hBC50).
- R2: The wait-for-lock phase ends after LOCK_CYCLES consecutive cycles with lock_i high. Any cycle with lock_i low restarts that count from zero.
- R3: sync_req_o is high in the wait-for-lock and sync-burst phases, and tx_word_o then equals SYNC_WORD. In the flag-burst phase, sync_req_o is low and tx_word_o is 16'hA501.
- R4: With no progress from the far end, the controller spends BURST_CYCLES cycles in the sync burst and then BURST_CYCLES cycles in the flag burst, and keeps alternating between the two.
- R5: In both bursts, a received 16'hA501, 16'hA502 or 16'hA503 adds one to the match count. A received SYNC_WORD leaves the count unchanged. Any other word clears it. The count is kept when the controller switches between the two bursts. The cycle on which the count reaches MATCH_CYCLES moves the controller to the first acknowledge phase, where tx_word_o is 16'hA502.
- R6: A cycle with lock_i low, in any phase other than wait-for-lock, returns the controller to wait-for-lock on the next edge, with all counts cleared.
- R7: In the first acknowledge phase, ACK_CYCLES consecutive received words of 16'hA502 or 16'hA503 move the controller to the second acknowledge phase, where tx_word_o is 16'hA503. Any other received word clears the count.
- R8: The second acknowledge phase ends in the connected phase after ACK_CYCLES consecutive received 16'hA503 words, or after TIMEOUT_CYCLES cycles spent in the phase, whichever comes first. Any other received word clears the consecutive count only.
- R9: In the connected phase, link_up_o is 1, sync_req_o is 0, and tx_word_o follows user_data_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Local transceiver reports lock to the incoming stream |
| rx_word_i | input | DATA_W | Word received from the far peer |
| user_data_i | input | DATA_W | Payload to send once the link is up |
| sync_req_o | output | 1 | Asks the transceiver to send its sync pattern |
| tx_word_o | output | DATA_W | Word handed to the transceiver for transmission |
| link_up_o | output | 1 | Link established; user data is on the transmit path |

## Verification
The checker assumes the block is never inspected during reset. It also assumes user_data_i is free to take any value, including a flag code, once the link is up. For that reason the properties that infer the phase from tx_word_o exclude cycles where link_up_o is high. The bench keeps the reduced configuration at BURST_CYCLES greater than MATCH_CYCLES, so a match run can finish inside a single burst. It changes lock_i and rx_word_i only on falling edges, so each input value is seen by exactly one rising edge, and it counts the phase lengths from that edge.

// File: rtl/lhs_pkg.sv
package lhs_pkg;

   typedef enum logic [2:0] {
      PH_WAIT_LOCK = 3'd0,
      PH_SYNC_BURST = 3'd1,
      PH_FLAG_BURST = 3'd2,
      PH_ACK_ONE = 3'd3,
      PH_ACK_TWO = 3'd4,
      PH_LINKED = 3'd5
   } phase_t;

   // Flag codes rise with the phase, so "at or beyond" is a magnitude compare.
   localparam logic [15:0] FLAG_BURST_CODE = 16'hA501;
   localparam logic [15:0] FLAG_ACK1_CODE  = 16'hA502;
   localparam logic [15:0] FLAG_ACK2_CODE  = 16'hA503;

   // Rank of a received word: 0 foreign, 1 burst, 2 first ack, 3 second ack.
   typedef logic [1:0] rank_t;

endpackage

// File: rtl/lhs_flag_decode.sv
module lhs_flag_decode #(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] SYNC_WORD = DATA_W'(16'hBC50)
) (
   input  logic [DATA_W-1:0] word_i,
   output lhs_pkg::rank_t    rank_o,
   output logic              is_sync_o
);
   import lhs_pkg::*;

   localparam logic [DATA_W-1:0] CODE_B  = DATA_W'(FLAG_BURST_CODE);
   localparam logic [DATA_W-1:0] CODE_A1 = DATA_W'(FLAG_ACK1_CODE);
   localparam logic [DATA_W-1:0] CODE_A2 = DATA_W'(FLAG_ACK2_CODE);

   always_comb begin
      if (word_i == CODE_A2)      rank_o = 2'd3;
      else if (word_i == CODE_A1) rank_o = 2'd2;
      else if (word_i == CODE_B)  rank_o = 2'd1;
      else                        rank_o = 2'd0;
   end

   assign is_sync_o = (word_i == SYNC_WORD);

endmodule

// File: rtl/lhs_counter.sv
module lhs_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= '0;
      else if (clr_i) q_o <= '0;
      else if (inc_i) q_o <= q_o + W'(1);
   end
endmodule

// File: rtl/link_handshake.sv
module link_handshake #(
   parameter int DATA_W         = 16,
   parameter logic [DATA_W-1:0] SYNC_WORD = DATA_W'(16'hBC50),
   parameter int LOCK_CYCLES    = 32'h0020_0000,
   parameter int BURST_CYCLES   = 240,
   parameter int MATCH_CYCLES   = 32'h0000_0FFF,
   parameter int ACK_CYCLES     = 240,
   parameter int TIMEOUT_CYCLES = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_i,
   input  logic [DATA_W-1:0] rx_word_i,
   input  logic [DATA_W-1:0] user_data_i,
   output logic              sync_req_o,
   output logic [DATA_W-1:0] tx_word_o,
   output logic              link_up_o
);
   import lhs_pkg::*;

   localparam int CYC_MAX_A = (LOCK_CYCLES > BURST_CYCLES) ? LOCK_CYCLES : BURST_CYCLES;
   localparam int CYC_MAX   = (CYC_MAX_A > TIMEOUT_CYCLES) ? CYC_MAX_A : TIMEOUT_CYCLES;
   localparam int MAT_MAX   = (MATCH_CYCLES > ACK_CYCLES) ? MATCH_CYCLES : ACK_CYCLES;
   localparam int CYC_W     = $clog2(CYC_MAX + 1);
   localparam int MAT_W     = $clog2(MAT_MAX + 1);

   localparam logic [CYC_W-1:0] LOCK_LAST  = CYC_W'(LOCK_CYCLES - 1);
   localparam logic [CYC_W-1:0] BURST_LAST = CYC_W'(BURST_CYCLES - 1);
   localparam logic [CYC_W-1:0] TMO_LAST   = CYC_W'(TIMEOUT_CYCLES - 1);
   localparam logic [MAT_W-1:0] MATCH_LAST = MAT_W'(MATCH_CYCLES - 1);
   localparam logic [MAT_W-1:0] ACK_LAST   = MAT_W'(ACK_CYCLES - 1);

   generate
      if (DATA_W < 16) begin : g_bad_width
         $error("link_handshake: DATA_W must hold the 16-bit flag codes");
      end
      if (LOCK_CYCLES < 1 || BURST_CYCLES < 1 || MATCH_CYCLES < 1 ||
          ACK_CYCLES < 1 || TIMEOUT_CYCLES < 1) begin : g_bad_count
         $error("link_handshake: every cycle threshold must be at least 1");
      end
   endgenerate

   phase_t            ph_q, ph_d;
   logic [CYC_W-1:0]  cyc_q;
   logic [MAT_W-1:0]  mat_q;
   logic              cyc_clr, cyc_inc, mat_clr, mat_inc;
   rank_t             rx_rank;
   logic              rx_sync;

   lhs_flag_decode #(.DATA_W(DATA_W), .SYNC_WORD(SYNC_WORD)) u_dec (
      .word_i    (rx_word_i),
      .rank_o    (rx_rank),
      .is_sync_o (rx_sync)
   );

   lhs_counter #(.W(CYC_W)) u_cyc (
      .clk (clk), .rst_n (rst_n), .clr_i (cyc_clr), .inc_i (cyc_inc), .q_o (cyc_q)
   );

   lhs_counter #(.W(MAT_W)) u_mat (
      .clk (clk), .rst_n (rst_n), .clr_i (mat_clr), .inc_i (mat_inc), .q_o (mat_q)
   );

   always_comb begin
      ph_d    = ph_q;
      cyc_clr = 1'b0;
      cyc_inc = 1'b0;
      mat_clr = 1'b0;
      mat_inc = 1'b0;
      if (ph_q != PH_WAIT_LOCK && !lock_i) begin
         ph_d    = PH_WAIT_LOCK;
         cyc_clr = 1'b1;
         mat_clr = 1'b1;
      end else begin
         unique case (ph_q)
            PH_WAIT_LOCK: begin
               if (!lock_i) begin
                  cyc_clr = 1'b1;
               end else if (cyc_q == LOCK_LAST) begin
                  ph_d    = PH_SYNC_BURST;
                  cyc_clr = 1'b1;
                  mat_clr = 1'b1;
               end else begin
                  cyc_inc = 1'b1;
               end
            end
            PH_SYNC_BURST, PH_FLAG_BURST: begin
               if (rx_rank != 2'd0 && mat_q == MATCH_LAST) begin
                  ph_d    = PH_ACK_ONE;
                  cyc_clr = 1'b1;
                  mat_clr = 1'b1;
               end else begin
                  if (rx_rank != 2'd0) mat_inc = 1'b1;
                  else if (!rx_sync)   mat_clr = 1'b1;
                  if (cyc_q == BURST_LAST) begin
                     ph_d    = (ph_q == PH_SYNC_BURST) ? PH_FLAG_BURST : PH_SYNC_BURST;
                     cyc_clr = 1'b1;
                  end else begin
                     cyc_inc = 1'b1;
                  end
               end
            end
            PH_ACK_ONE: begin
               if (rx_rank >= 2'd2) begin
                  if (mat_q == ACK_LAST) begin
                     ph_d    = PH_ACK_TWO;
                     cyc_clr = 1'b1;
                     mat_clr = 1'b1;
                  end else begin
                     mat_inc = 1'b1;
                  end
               end else begin
                  mat_clr = 1'b1;
               end
            end
            PH_ACK_TWO: begin
               if ((rx_rank == 2'd3 && mat_q == ACK_LAST) || cyc_q == TMO_LAST) begin
                  ph_d    = PH_LINKED;
                  cyc_clr = 1'b1;
                  mat_clr = 1'b1;
               end else begin
                  cyc_inc = 1'b1;
                  if (rx_rank == 2'd3) mat_inc = 1'b1;
                  else                 mat_clr = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_WAIT_LOCK;
      else        ph_q <= ph_d;
   end

   always_comb begin
      unique case (ph_q)
         PH_FLAG_BURST: tx_word_o = DATA_W'(FLAG_BURST_CODE);
         PH_ACK_ONE:    tx_word_o = DATA_W'(FLAG_ACK1_CODE);
         PH_ACK_TWO:    tx_word_o = DATA_W'(FLAG_ACK2_CODE);
         PH_LINKED:     tx_word_o = user_data_i;
         default:       tx_word_o = SYNC_WORD;
      endcase
   end

   assign sync_req_o = (ph_q == PH_WAIT_LOCK) || (ph_q == PH_SYNC_BURST);
   assign link_up_o  = (ph_q == PH_LINKED);

endmodule

// File: rtl/lhs_checker.sv
module lhs_checker #(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] SYNC_WORD = DATA_W'(16'hBC50)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lock_i,
   input logic [DATA_W-1:0] user_data_i,
   input logic              sync_req_o,
   input logic [DATA_W-1:0] tx_word_o,
   input logic              link_up_o
);
   import lhs_pkg::*;

   localparam logic [DATA_W-1:0] CODE_B  = DATA_W'(FLAG_BURST_CODE);
   localparam logic [DATA_W-1:0] CODE_A1 = DATA_W'(FLAG_ACK1_CODE);
   localparam logic [DATA_W-1:0] CODE_A2 = DATA_W'(FLAG_ACK2_CODE);

   AST_LINKED_PASSES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      link_up_o |-> (tx_word_o == user_data_i && !sync_req_o)); // R9

   AST_LOCK_DROP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_i |=> (sync_req_o && !link_up_o && tx_word_o == SYNC_WORD)); // R6

   AST_SYNC_REQ_SENDS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req_o |-> (tx_word_o == SYNC_WORD && !link_up_o)); // R3

   AST_LINK_FROM_ACK_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_up_o) |-> ($past(tx_word_o) == CODE_A2)); // R8

   AST_ACK_ONE_FROM_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up_o && !$past(link_up_o) && tx_word_o == CODE_A1 && $past(tx_word_o) != CODE_A1)
      |-> ($past(tx_word_o) == SYNC_WORD || $past(tx_word_o) == CODE_B)); // R5

   AST_ACK_TWO_FROM_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up_o && !$past(link_up_o) && tx_word_o == CODE_A2 && $past(tx_word_o) != CODE_A2)
      |-> ($past(tx_word_o) == CODE_A1)); // R7

endmodule

bind link_handshake lhs_checker #(.DATA_W(DATA_W), .SYNC_WORD(SYNC_WORD)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lock_i      (lock_i),
   .user_data_i (user_data_i),
   .sync_req_o  (sync_req_o),
   .tx_word_o   (tx_word_o),
   .link_up_o   (link_up_o)
);

// File: tb/sim_link_handshake.sv
`timescale 1ns/1ps
module sim_link_handshake;
   localparam int LOCK  = 16;
   localparam int BURST = 8;
   localparam int MATCH = 5;
   localparam int ACK   = 4;
   localparam int TMO   = 20;
   localparam logic [15:0] SYNC = 16'hBC50;
   localparam logic [15:0] FB = 16'hA501, A1 = 16'hA502, A2 = 16'hA503;
   localparam logic [15:0] JUNK = 16'h1234;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lock = 1'b0;
   logic [15:0] rx = SYNC;
   logic [15:0] ud = 16'h0000;
   logic sync_req, link_up;
   logic [15:0] tx;
   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   link_handshake #(
      .DATA_W(16), .SYNC_WORD(SYNC), .LOCK_CYCLES(LOCK), .BURST_CYCLES(BURST),
      .MATCH_CYCLES(MATCH), .ACK_CYCLES(ACK), .TIMEOUT_CYCLES(TMO)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .lock_i(lock), .rx_word_i(rx), .user_data_i(ud),
      .sync_req_o(sync_req), .tx_word_o(tx), .link_up_o(link_up)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_out(input string req, input logic es, input logic [15:0] et,
                             input logic el);
      total++;
      if (sync_req !== es || tx !== et || link_up !== el) begin
         bad++;
         $display("FAIL %s: actual sync=%b tx=%h link=%b expected sync=%b tx=%h link=%b",
                  req, sync_req, tx, link_up, es, et, el);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      lock = 1'b0;
      rx = SYNC;
      tick(2);
      rst_n = 1'b1;
      lock = 1'b1;
   endtask

   task automatic to_flag_burst();
      do_reset();
      tick(LOCK + BURST);
   endtask

   task automatic to_ack_one();
      to_flag_burst();
      rx = FB;
      tick(MATCH);
   endtask

   task automatic to_ack_two();
      to_ack_one();
      rx = A1;
      tick(ACK);
   endtask

   initial begin
      // R1: reset values
      tick(1);
      expect_out("R1 in reset", 1'b1, SYNC, 1'b0);
      rst_n = 1'b1;
      tick(1);
      expect_out("R1 after release", 1'b1, SYNC, 1'b0);

      // R2 / R3: lock duration to first flag word
      do_reset();
      tick(LOCK + BURST - 1);
      expect_out("R2 one cycle short", 1'b1, SYNC, 1'b0);
      tick(1);
      expect_out("R3 flag burst word", 1'b0, FB, 1'b0);

      // R2: a lock gap restarts the count, at each gap position
      for (int g = 1; g < LOCK; g += 5) begin
         do_reset();
         tick(g);
         lock = 1'b0;
         tick(1);
         lock = 1'b1;
         tick(LOCK + BURST - 1);
         expect_out("R2 restart short", 1'b1, SYNC, 1'b0);
         tick(1);
         expect_out("R2 restart done", 1'b0, FB, 1'b0);
      end

      // R4: alternation with neutral input
      to_flag_burst();
      for (int i = 1; i <= 4 * BURST; i++) begin
         tick(1);
         if (((i / BURST) % 2) == 0) expect_out("R4 flag phase", 1'b0, FB, 1'b0);
         else                        expect_out("R4 sync phase", 1'b1, SYNC, 1'b0);
      end

      // R5: sync word holds the count
      to_flag_burst();
      rx = FB; tick(3);
      rx = SYNC; tick(1);
      rx = FB; tick(1);
      expect_out("R5 held count short", 1'b0, FB, 1'b0);
      rx = A2; tick(1);
      expect_out("R5 reached ack one", 1'b0, A1, 1'b0);

      // R5: foreign word clears; count survives the burst switch
      to_flag_burst();
      rx = FB; tick(4);
      rx = JUNK; tick(1);
      rx = FB; tick(3);
      expect_out("R5 cleared then burst swap", 1'b1, SYNC, 1'b0);
      tick(1);
      expect_out("R5 four after clear", 1'b1, SYNC, 1'b0);
      tick(1);
      expect_out("R5 count kept across swap", 1'b0, A1, 1'b0);

      // R6: lock loss in flag burst
      to_flag_burst();
      lock = 1'b0; tick(1);
      expect_out("R6 back to wait", 1'b1, SYNC, 1'b0);
      lock = 1'b1;
      tick(LOCK + BURST - 1);
      expect_out("R6 full wait again", 1'b1, SYNC, 1'b0);
      tick(1);
      expect_out("R6 flag after rewait", 1'b0, FB, 1'b0);

      // R7: first acknowledge, with clears
      to_ack_one();
      rx = A2; tick(2);
      rx = FB; tick(1);
      rx = A1; tick(ACK - 1);
      expect_out("R7 one short", 1'b0, A1, 1'b0);
      tick(1);
      expect_out("R7 to ack two", 1'b0, A2, 1'b0);

      // R6: lock loss in first acknowledge
      to_ack_one();
      lock = 1'b0; tick(1);
      expect_out("R6 from ack one", 1'b1, SYNC, 1'b0);
      lock = 1'b1;

      // R8: consecutive match path with a clear
      to_ack_two();
      rx = A2; tick(ACK - 1);
      rx = A1; tick(1);
      rx = A2; tick(ACK - 1);
      expect_out("R8 match short", 1'b0, A2, 1'b0);
      tick(1);
      expect_out("R8 match connects", 1'b0, ud, 1'b1);

      // R8: timeout path
      to_ack_two();
      rx = JUNK;
      tick(TMO - 1);
      expect_out("R8 timeout short", 1'b0, A2, 1'b0);
      tick(1);
      expect_out("R8 timeout connects", 1'b0, ud, 1'b1);

      // R9: data pass-through sweep, including flag-like values
      for (int v = 0; v < 20; v++) begin
         ud = 16'(v * 16'h0B3D) ^ ((v == 7) ? 16'h0000 : 16'h0000);
         if (v == 5) ud = A1;
         if (v == 6) ud = SYNC;
         #1;
         expect_out("R9 user data", 1'b0, ud, 1'b1);
         tick(1);
      end

      // R6: lock loss when connected
      lock = 1'b0; tick(1);
      expect_out("R6 from connected", 1'b1, SYNC, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule